// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital control for a dual-slope integrating analog-to-digital converter. The integrator, the zero-crossing comparator and the reference source are outside it. A start strobe begins a conversion, which runs in three steps:

- The integrator is drained for a fixed number of clocks.
- The unknown input is switched onto the integrator for a fixed number of clocks.
- The reference is switched on and the integrator ramps back toward zero at a fixed slope.

One shared counter times every step. It restarts from zero at each step. During the reference step, the count reached when the comparator reports zero is the conversion result. If the comparator never reports zero within the counter's range, the result saturates at all ones and an overflow flag is set.

The integration time is the same for every conversion and the reference slope is fixed. The result is therefore proportional to the average input over the integration window. The result stays latched until the next conversion ends, and a one-clock done pulse marks each new value.

Top module: `dual_slope_seq`

## Requirements
- R1: In the first cycle after reset, all of these are 0: `discharge`, `sel_in`, `sel_ref`, `result`, `overflow` and `done`.
- R2: A start sampled while idle gives exactly DRAIN_CYC cycles with `discharge` high. During those cycles `sel_in` and `sel_ref` are both low.
- R3: Right after the drain, `sel_in` is high for exactly SIG_CYC cycles.
- R4: Right after the signal step, `sel_ref` is high until the result is captured. At most one of `discharge`, `sel_in` and `sel_ref` is high in any cycle.
- R5: The reference step has cycles numbered 0, 1, 2 and so on. `result` becomes the number of the first of those cycles in which `cmp_zero` is sampled high. `cmp_zero` has no effect outside the reference step.
- R6: If `cmp_zero` is still low in reference cycle 2**RES_W-1, the conversion ends there. `result` becomes all ones and `overflow` goes to 1. A conversion that ends on a zero crossing clears `overflow` to 0.
- R7: `done` is high for exactly one cycle, the cycle after the capture cycle. `result` and `overflow` take their new values in that same cycle and hold them until the next `done`.
- R8: A start strobe during a conversion is ignored: the conversion's timing and result do not change. No new conversion begins after `done` unless start is sampled again while idle.
- R9: The `done` pulse appears DRAIN_CYC + SIG_CYC + k + 2 cycles after the clock edge that samples start. Here k is the reference cycle in which capture happens (k = 2**RES_W-1 on overflow).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request; acted on only while idle |
| cmp_zero | input | 1 | Comparator: integrator at or below zero |
| sel_in | output | 1 | Connects the unknown input to the integrator |
| sel_ref | output | 1 | Connects the reference to the integrator |
| discharge | output | 1 | Shorts the integrator capacitor |
| result | output | RES_W | Latched conversion count |
| overflow | output | 1 | Last conversion saturated |
| done | output | 1 | One-cycle pulse with each new result |

## Verification
Every conversion has a known length. Its `done` pulse falls DRAIN_CYC + SIG_CYC + k + 2 cycles after the start edge, and the bench predicts k from the integrator level and the reference slope it applies. The bench starts counting cycles at the edge that samples start and samples on falling edges. It counts the cycles of each switch phase and checks that total against the cycle in which `done` is first seen. `result` and `overflow` are checked in that same cycle, and again a few cycles later to confirm that they hold and that no new conversion has started.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DRAIN  = 2'd1,
        PH_SIGNAL = 2'd2,
        PH_REFER  = 2'd3
    } phase_e;

    typedef struct packed {
        logic drain;
        logic take_sig;
        logic take_ref;
    } switch_s;

    typedef struct packed {
        logic clr;
        logic en;
        logic capture;
        logic sat;
    } seq_ctl_s;

    function automatic switch_s switches_for(phase_e p);
        switch_s s;
        s.drain    = (p == PH_DRAIN);
        s.take_sig = (p == PH_SIGNAL);
        s.take_ref = (p == PH_REFER);
        return s;
    endfunction

    function automatic int span_of(int a, int b, int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/ds_counter.sv
module ds_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst || clr) value <= '0;
        else if (en)    value <= value + 1'b1;
    end
endmodule

// File: rtl/ds_phase_ctrl.sv
module ds_phase_ctrl
    import dslope_pkg::*;
#(
    parameter int TMR_W     = 9,
    parameter int RES_W     = 8,
    parameter int DRAIN_CYC = 4,
    parameter int SIG_CYC   = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_zero,
    input  logic [TMR_W-1:0] count,
    output phase_e           phase,
    output seq_ctl_s         ctl
);
    localparam logic [TMR_W-1:0] DRAIN_LAST = TMR_W'(DRAIN_CYC - 1);
    localparam logic [TMR_W-1:0] SIG_LAST   = TMR_W'(SIG_CYC - 1);
    localparam logic [TMR_W-1:0] REF_LAST   = TMR_W'((1 << RES_W) - 1);

    phase_e nxt;

    always_comb begin
        nxt = phase;
        ctl = '0;
        unique case (phase)
            PH_IDLE: begin
                ctl.clr = 1'b1;
                if (start) nxt = PH_DRAIN;
            end
            PH_DRAIN: begin
                if (count == DRAIN_LAST) begin
                    ctl.clr = 1'b1;
                    nxt     = PH_SIGNAL;
                end else begin
                    ctl.en = 1'b1;
                end
            end
            PH_SIGNAL: begin
                if (count == SIG_LAST) begin
                    ctl.clr = 1'b1;
                    nxt     = PH_REFER;
                end else begin
                    ctl.en = 1'b1;
                end
            end
            PH_REFER: begin
                if (cmp_zero) begin
                    ctl.capture = 1'b1;
                    ctl.clr     = 1'b1;
                    nxt         = PH_IDLE;
                end else if (count == REF_LAST) begin
                    ctl.capture = 1'b1;
                    ctl.sat     = 1'b1;
                    ctl.clr     = 1'b1;
                    nxt         = PH_IDLE;
                end else begin
                    ctl.en = 1'b1;
                end
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

    // R3
    sig_window_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SIGNAL) |-> (count <= SIG_LAST));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SIGNAL && start) |=> (phase == PH_SIGNAL || phase == PH_REFER));

    // R2
    drain_first_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start) |=> (phase == PH_DRAIN && count == '0));

endmodule

// File: rtl/ds_result_reg.sv
module ds_result_reg #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             sat,
    input  logic [RES_W-1:0] count,
    output logic [RES_W-1:0] result,
    output logic             overflow,
    output logic             done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result   <= '0;
            overflow <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= capture;
            if (capture) begin
                result   <= sat ? '1 : count;
                overflow <= sat;
            end
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R6
    sat_value_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (result == '1));

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
    import dslope_pkg::*;
#(
    parameter int RES_W     = 8,
    parameter int DRAIN_CYC = 4,
    parameter int SIG_CYC   = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_zero,
    output logic             sel_in,
    output logic             sel_ref,
    output logic             discharge,
    output logic [RES_W-1:0] result,
    output logic             overflow,
    output logic             done
);
    localparam int SPAN  = span_of(DRAIN_CYC, SIG_CYC, 1 << RES_W);
    localparam int TMR_W = $clog2(SPAN + 1);

    logic [TMR_W-1:0] count;
    phase_e           phase;
    seq_ctl_s         ctl;
    switch_s          sw;

    ds_counter #(.W(TMR_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctl.clr),
        .en    (ctl.en),
        .value (count)
    );

    ds_phase_ctrl #(
        .TMR_W     (TMR_W),
        .RES_W     (RES_W),
        .DRAIN_CYC (DRAIN_CYC),
        .SIG_CYC   (SIG_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmp_zero (cmp_zero),
        .count    (count),
        .phase    (phase),
        .ctl      (ctl)
    );

    ds_result_reg #(.RES_W(RES_W)) u_res (
        .clk      (clk),
        .rst      (rst),
        .capture  (ctl.capture),
        .sat      (ctl.sat),
        .count    (count[RES_W-1:0]),
        .result   (result),
        .overflow (overflow),
        .done     (done)
    );

    assign sw        = switches_for(phase);
    assign discharge = sw.drain;
    assign sel_in    = sw.take_sig;
    assign sel_ref   = sw.take_ref;

    // R4
    switch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({discharge, sel_in, sel_ref}));

    // R4
    ref_after_sig_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_in) |-> sel_ref);

    // R5
    done_from_ref_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(sel_ref));

    // R2
    sig_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_in) |-> $past(discharge));

endmodule

// File: tb/dual_slope_seq_test.sv
`timescale 1ns/1ps
module dual_slope_seq_test;
    localparam int RES_W     = 8;
    localparam int DRAIN_CYC = 4;
    localparam int SIG_CYC   = 128;
    localparam int RMAX      = (1 << RES_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic cmp_zero;
    logic sel_in, sel_ref, discharge, overflow, done;
    logic [RES_W-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int a_lvl    = 0;
    int ref_lvl  = 128;
    int integ    = 0;

    always #4 clk = ~clk;

    dual_slope_seq #(.RES_W(RES_W), .DRAIN_CYC(DRAIN_CYC), .SIG_CYC(SIG_CYC)) uut (
        .clk(clk), .rst(rst), .start(start), .cmp_zero(cmp_zero),
        .sel_in(sel_in), .sel_ref(sel_ref), .discharge(discharge),
        .result(result), .overflow(overflow), .done(done)
    );

    // behavioural integrator and comparator
    always @(posedge clk) begin
        if (rst || discharge) integ <= 0;
        else if (sel_in)      integ <= integ + a_lvl;
        else if (sel_ref)     integ <= integ - ref_lvl;
    end
    assign cmp_zero = (integ <= 0);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int crossing(input int a, input int r);
        return (SIG_CYC * a + r - 1) / r;
    endfunction

    task automatic convert(input int a, input int r, input int poke_at);
        int k, refc, exp_res, exp_ovf, cyc, nd, ni, nr, nb;
        a_lvl = a; ref_lvl = r;
        k = crossing(a, r);
        exp_ovf = (k > RMAX) ? 1 : 0;
        if (exp_ovf == 1) k = RMAX;
        exp_res = k;
        refc = k + 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 1; nd = 0; ni = 0; nr = 0; nb = 0;
        while (!done && cyc < 2000) begin
            if (discharge) nd++;
            if (sel_in) ni++;
            if (sel_ref) nr++;
            if (int'(discharge) + int'(sel_in) + int'(sel_ref) > 1) nb++;
            if (discharge && (sel_in || sel_ref)) nb++;
            if (cyc == poke_at) start = 1'b1;
            @(negedge clk); start = 1'b0;
            cyc++;
        end
        check(nd == DRAIN_CYC, "R2 drain cycles", nd, DRAIN_CYC);
        check(ni == SIG_CYC, "R3 signal cycles", ni, SIG_CYC);
        check(nr == refc, "R4 reference cycles", nr, refc);
        check(nb == 0, "R4 switch exclusivity", nb, 0);
        check(cyc == DRAIN_CYC + SIG_CYC + refc + 1, "R9 done latency", cyc, DRAIN_CYC + SIG_CYC + refc + 1);
        check(int'(result) == exp_res, exp_ovf ? "R6 saturated result" : "R5 result", int'(result), exp_res);
        check(int'(overflow) == exp_ovf, "R6 overflow flag", int'(overflow), exp_ovf);
        @(negedge clk);
        check(done == 1'b0, "R7 done one cycle", int'(done), 0);
        @(negedge clk);
        @(negedge clk);
        check(int'(result) == exp_res, "R7 result held", int'(result), exp_res);
        check(!discharge && !sel_in && !sel_ref, "R8 no restart", int'({discharge, sel_in, sel_ref}), 0);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        int a, r;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!discharge && !sel_in && !sel_ref && !done && !overflow && result == '0,
              "R1 reset state", int'({discharge, sel_in, sel_ref, done, overflow}), 0);
        // directed corners
        convert(0, 128, 0);          // R5 immediate crossing
        convert(255, 128, 0);        // R5 exact top count
        convert(256, 128, 0);        // R6 overflow
        convert(3, 100, 0);          // R6 overflow cleared
        convert(1000, 64, 0);        // R6 deep overflow
        convert(77, 128, 3);         // R8 start during drain
        convert(150, 90, DRAIN_CYC + SIG_CYC + 5); // R8 start during reference step
        // random conversions
        for (int i = 0; i < 40; i++) begin
            r = 32 + int'($urandom_range(0, 200));
            a = int'($urandom_range(0, 300));
            convert(a, r, (i % 4 == 0) ? DRAIN_CYC + 10 : 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule